// File: doc/BRIEF.md
# Timer Compare and Capture Channel Bank

This block holds a bank of timer channels that all watch one shared free-running count, which arrives as an input. Five compare channels each hold a 16-bit match value. Each one raises its own flag when the shared count reaches that value. Three capture channels each watch an external pin. When the pin shows the edge chosen for that channel, the channel copies the current count into its own latch and raises its flag.

All eight flags sit in one packed flag register. A flag is cleared by writing a one to its bit. A mask register with the same bit layout gates the flags onto a single interrupt line. A third register holds a two-bit edge code for each capture pin.

Software reaches every register through a simple single-cycle write port and a combinational read port. Register map:

| Address | Register |
|---|---|
| 0–4 | compare values, channels 1–5 |
| 5–7 | capture latches, channels 1–3 |
| 8 | flags |
| 9 | mask |
| 10 | edge codes |

Top module: `tmr_chan_bank`

## Requirements
- R1: After reset, every compare value reads 0xFFFF. The capture latches, flag, mask and edge registers read 0, and the interrupt output is low.
- R2: A compare channel's flag is set on the clock edge that follows a cycle in which the shared count equals that channel's compare value.
- R3: A compare value written while it equals the current count does not set the flag for that equality, even if the count holds still afterwards. Only a later fresh match sets it.
- R4: With edge code 01, a rising pin edge latches the count and sets the flag. The latched value is the count that was present when the pin changed, plus two, because the pin passes through a two-flop synchronizer.
- R5: With edge code 10, only a falling pin edge latches the count (again the count at the pin change plus two) and sets the flag.
- R6: With edge code 11, both rising and falling pin edges latch and flag.
- R7: With edge code 00, pin edges change neither the latch nor the flag.
- R8: Writing the flag register clears exactly those flags whose data bit is 1. Data bits that are 0 leave their flags unchanged.
- R9: The interrupt output is high exactly when some flag bit and the same mask bit are both 1.
- R10: Flag and mask bit positions are as follows. Compare channels 1–5 map to bits 7–3. Capture channels 1–3 map to bits 2–0. In the edge register, capture channel 1 uses bits [5:4], channel 2 uses [3:2] and channel 3 uses [1:0].
- R11: Writes to the capture-latch addresses are ignored. Reading them back still returns the latched count.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cnt_i | input | 16 | Shared free-running count |
| cap_pin_i | input | 3 | Capture pins; bit j belongs to capture channel j+1 |
| wr_en_i | input | 1 | Register write strobe |
| wr_addr_i | input | 4 | Write address |
| wr_data_i | input | 16 | Write data |
| rd_addr_i | input | 4 | Read address |
| rd_data_o | output | 16 | Read data, combinational |
| irq_o | output | 1 | Combined interrupt |

## Verification
The assertions take for granted that the capture pins are held low through reset. A pin that is already high when reset ends would show up as a rising edge. They also assume that the count does not revisit a written compare value by wrapping during a check window. The stimulus keeps every pin low until reset has been released. The stimulus runs for far fewer than 65536 cycles, so no stale compare value is matched again. Where R3 needs the count to stand still, the bench freezes it while the equal value is written.

// File: rtl/tmr_chan_pkg.sv
// Shared types and constants for the timer channel bank.
// Assumes: flag/mask vectors fit in one data word (N_CH <= CNT_W).
package tmr_chan_pkg;
    // Two-bit edge selector of a capture channel.
    typedef enum logic [1:0] {
        EDGE_OFF  = 2'b00,
        EDGE_RISE = 2'b01,
        EDGE_FALL = 2'b10,
        EDGE_BOTH = 2'b11
    } edge_mode_e;

    localparam int EDGE_W = 2;
endpackage

// File: rtl/tmr_cmp_chan.sv
// One compare channel: holds a match value and pulses hit_o for a cycle
// in which the shared count equals it. An equality already present on the
// cycle the value is written is treated as seen and does not pulse.
// Assumes: cnt_i is synchronous to clk.
module tmr_cmp_chan #(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [CNT_W-1:0] cnt_i,
    input  logic             wr_i,
    input  logic [CNT_W-1:0] wr_val_i,
    output logic [CNT_W-1:0] val_o,
    output logic             hit_o
);
    logic [CNT_W-1:0] val_q;
    logic             seen_q;
    logic             match;

    assign match = (val_q == cnt_i);

    // Match value register; resets to all ones.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            val_q <= '1;
        end else if (wr_i) begin
            val_q <= wr_val_i;
        end
    end

    // Remembers an equality already reported or present at write time.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            seen_q <= 1'b1;
        end else if (wr_i) begin
            seen_q <= (wr_val_i == cnt_i);
        end else begin
            seen_q <= match;
        end
    end

    assign hit_o = match && !seen_q;
    assign val_o = val_q;

    // R3
    wr_equal_no_hit_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_i && wr_val_i == cnt_i) |=> !hit_o);

    // R2
    hit_is_equal_chk: assert property (@(posedge clk) disable iff (!rst_n)
        hit_o |-> (val_o == cnt_i));
endmodule

// File: rtl/tmr_cap_chan.sv
// One capture channel: synchronises its pin, detects the edge chosen by
// mode_i and, on that edge, latches the shared count and pulses hit_o.
// Assumes: pin is low during reset; SYNC_STAGES >= 2.
module tmr_cap_chan
    import tmr_chan_pkg::*;
#(
    parameter int CNT_W       = 16,
    parameter int SYNC_STAGES = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             pin_i,
    input  edge_mode_e       mode_i,
    input  logic [CNT_W-1:0] cnt_i,
    output logic [CNT_W-1:0] val_o,
    output logic             hit_o
);
    logic [SYNC_STAGES-1:0] sync_q;
    logic                   prev_q;
    logic                   lvl;
    logic                   rise;
    logic                   fall;
    logic [CNT_W-1:0]       val_q;

    // Multi-flop synchroniser for the asynchronous pin.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sync_q <= '0;
        end else begin
            sync_q <= {sync_q[SYNC_STAGES-2:0], pin_i};
        end
    end

    assign lvl = sync_q[SYNC_STAGES-1];

    // Previous synchronised level for edge detection.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            prev_q <= 1'b0;
        end else begin
            prev_q <= lvl;
        end
    end

    assign rise = lvl && !prev_q;
    assign fall = !lvl && prev_q;

    // Edge qualification by the channel's selector.
    always_comb begin
        unique case (mode_i)
            EDGE_RISE: hit_o = rise;
            EDGE_FALL: hit_o = fall;
            EDGE_BOTH: hit_o = rise || fall;
            default:   hit_o = 1'b0;
        endcase
    end

    // Capture latch loaded on a qualified edge.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            val_q <= '0;
        end else if (hit_o) begin
            val_q <= cnt_i;
        end
    end

    assign val_o = val_q;

    // R4
    latch_takes_count_chk: assert property (@(posedge clk) disable iff (!rst_n)
        hit_o |=> (val_o == $past(cnt_i)));

    // R7
    off_holds_latch_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_i == EDGE_OFF) |=> $stable(val_o));

    // R5
    fall_only_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_i == EDGE_FALL && hit_o) |-> !lvl);
endmodule

// File: rtl/tmr_flag_bank.sv
// Packed event flags with write-one-to-clear, the matching enable mask and
// the combined interrupt. A set event wins over a clear in the same cycle.
// Assumes: set_i pulses and clr_i are single-cycle, synchronous to clk.
module tmr_flag_bank #(
    parameter int N_CH = 8
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic [N_CH-1:0] set_i,
    input  logic [N_CH-1:0] clr_i,
    input  logic            mask_wr_i,
    input  logic [N_CH-1:0] mask_val_i,
    output logic [N_CH-1:0] flags_o,
    output logic [N_CH-1:0] mask_o,
    output logic            irq_o
);
    logic [N_CH-1:0] flags_q;
    logic [N_CH-1:0] mask_q;

    // Flag state: set by events, cleared by one bits of a flag write.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            flags_q <= '0;
        end else begin
            flags_q <= (flags_q & ~clr_i) | set_i;
        end
    end

    // Enable mask register.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mask_q <= '0;
        end else if (mask_wr_i) begin
            mask_q <= mask_val_i;
        end
    end

    assign flags_o = flags_q;
    assign mask_o  = mask_q;
    assign irq_o   = |(flags_q & mask_q);

    for (genvar k = 0; k < N_CH; k++) begin : g_flag_chk
        // R8
        fall_needs_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
            $fell(flags_q[k]) |-> $past(clr_i[k]));

        // R2
        set_lands_chk: assert property (@(posedge clk) disable iff (!rst_n)
            set_i[k] |=> flags_q[k]);
    end

    // R9
    no_mask_no_irq_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (mask_q == '0) |-> !irq_o);
endmodule

// File: rtl/tmr_chan_bank.sv
// Bank of compare and capture channels sharing one free-running count,
// with a packed flag/mask pair, an edge-code register and one interrupt.
// Register map: compare values, capture latches, flags, mask, edge codes.
// Assumes: N_OC + N_IC <= CNT_W; address space holds every register.
module tmr_chan_bank
    import tmr_chan_pkg::*;
#(
    parameter int CNT_W       = 16,
    parameter int N_OC        = 5,
    parameter int N_IC        = 3,
    parameter int SYNC_STAGES = 2,
    parameter int AW          = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [CNT_W-1:0] cnt_i,
    input  logic [N_IC-1:0]  cap_pin_i,
    input  logic             wr_en_i,
    input  logic [AW-1:0]    wr_addr_i,
    input  logic [CNT_W-1:0] wr_data_i,
    input  logic [AW-1:0]    rd_addr_i,
    output logic [CNT_W-1:0] rd_data_o,
    output logic             irq_o
);
    localparam int N_CH      = N_OC + N_IC;
    localparam int OC_BASE   = 0;
    localparam int IC_BASE   = OC_BASE + N_OC;
    localparam int FLAG_ADDR = IC_BASE + N_IC;
    localparam int MASK_ADDR = FLAG_ADDR + 1;
    localparam int EDGE_ADDR = FLAG_ADDR + 2;
    localparam int EDGE_BITS = EDGE_W * N_IC;

    logic [CNT_W-1:0]     oc_val [N_OC];
    logic [CNT_W-1:0]     ic_val [N_IC];
    logic [N_CH-1:0]      set_vec;
    logic [N_CH-1:0]      clr_vec;
    logic [N_CH-1:0]      flags;
    logic [N_CH-1:0]      mask;
    logic [EDGE_BITS-1:0] edge_q;
    logic                 flag_wr;
    logic                 mask_wr;
    logic                 edge_wr;

    assign flag_wr = wr_en_i && (wr_addr_i == AW'(FLAG_ADDR));
    assign mask_wr = wr_en_i && (wr_addr_i == AW'(MASK_ADDR));
    assign edge_wr = wr_en_i && (wr_addr_i == AW'(EDGE_ADDR));
    assign clr_vec = flag_wr ? wr_data_i[N_CH-1:0] : '0;

    // Edge-code register, one two-bit field per capture channel.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            edge_q <= '0;
        end else if (edge_wr) begin
            edge_q <= wr_data_i[EDGE_BITS-1:0];
        end
    end

    for (genvar i = 0; i < N_OC; i++) begin : g_oc
        logic hit;
        tmr_cmp_chan #(.CNT_W(CNT_W)) u_cmp (
            .clk      (clk),
            .rst_n    (rst_n),
            .cnt_i    (cnt_i),
            .wr_i     (wr_en_i && (wr_addr_i == AW'(OC_BASE + i))),
            .wr_val_i (wr_data_i),
            .val_o    (oc_val[i]),
            .hit_o    (hit)
        );
        assign set_vec[N_CH-1-i] = hit;
    end

    for (genvar j = 0; j < N_IC; j++) begin : g_ic
        logic       hit;
        edge_mode_e mode;
        assign mode = edge_mode_e'(edge_q[EDGE_W*(N_IC-1-j) +: EDGE_W]);
        tmr_cap_chan #(.CNT_W(CNT_W), .SYNC_STAGES(SYNC_STAGES)) u_cap (
            .clk    (clk),
            .rst_n  (rst_n),
            .pin_i  (cap_pin_i[j]),
            .mode_i (mode),
            .cnt_i  (cnt_i),
            .val_o  (ic_val[j]),
            .hit_o  (hit)
        );
        assign set_vec[N_IC-1-j] = hit;
    end

    tmr_flag_bank #(.N_CH(N_CH)) u_flags (
        .clk        (clk),
        .rst_n      (rst_n),
        .set_i      (set_vec),
        .clr_i      (clr_vec),
        .mask_wr_i  (mask_wr),
        .mask_val_i (wr_data_i[N_CH-1:0]),
        .flags_o    (flags),
        .mask_o     (mask),
        .irq_o      (irq_o)
    );

    // Combinational read multiplexer over the register map.
    always_comb begin
        rd_data_o = '0;
        for (int i = 0; i < N_OC; i++) begin
            if (rd_addr_i == AW'(OC_BASE + i)) rd_data_o = oc_val[i];
        end
        for (int j = 0; j < N_IC; j++) begin
            if (rd_addr_i == AW'(IC_BASE + j)) rd_data_o = ic_val[j];
        end
        if (rd_addr_i == AW'(FLAG_ADDR)) rd_data_o = CNT_W'(flags);
        if (rd_addr_i == AW'(MASK_ADDR)) rd_data_o = CNT_W'(mask);
        if (rd_addr_i == AW'(EDGE_ADDR)) rd_data_o = CNT_W'(edge_q);
    end

    // R11
    cap_write_ignored_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en_i && wr_addr_i == AW'(IC_BASE) && set_vec[N_IC-1] == 1'b0)
        |=> $stable(ic_val[0]));

    // R1
    reset_irq_low_chk: assert property (@(posedge clk)
        $past(!rst_n) |-> !irq_o);
endmodule

// File: tb/test_tmr_chan_bank.sv
module test_tmr_chan_bank;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [15:0] cnt;
    logic        hold = 1'b0;
    logic [2:0]  pin = 3'b000;
    logic        wr_en = 1'b0;
    logic [3:0]  wr_addr = '0;
    logic [15:0] wr_data = '0;
    logic [3:0]  rd_addr = '0;
    logic [15:0] rd_data;
    logic        irq;
    int          n_chk = 0;
    int          n_bad = 0;

    always #2 clk = ~clk;

    always_ff @(posedge clk) begin
        if (!rst_n) cnt <= '0;
        else if (!hold) cnt <= cnt + 16'd1;
    end

    tmr_chan_bank i_tmr_chan_bank (
        .clk(clk), .rst_n(rst_n), .cnt_i(cnt), .cap_pin_i(pin),
        .wr_en_i(wr_en), .wr_addr_i(wr_addr), .wr_data_i(wr_data),
        .rd_addr_i(rd_addr), .rd_data_o(rd_data), .irq_o(irq)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [3:0] a, input logic [15:0] d);
        @(negedge clk);
        wr_en = 1'b1; wr_addr = a; wr_data = d;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic rd(input logic [3:0] a, output logic [15:0] d);
        @(negedge clk);
        rd_addr = a;
        #1 d = rd_data;
    endtask

    initial begin
        #800000;
        n_chk++; n_bad++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin
        logic [15:0] v, prev, c;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;

        // R1: reset values
        for (int a = 0; a < 11; a++) begin
            rd(4'(a), v);
            chk("R1", v, (a < 5) ? 16'hFFFF : 16'h0000);
        end
        chk("R1 irq", irq, 0);

        // R2/R10: each compare channel sets only its own bit
        for (int i = 0; i < 5; i++) begin
            wr(4'd8, 16'h00FF);
            @(negedge clk);
            wr_en = 1'b1; wr_addr = 4'(i); wr_data = cnt + 16'd5;
            @(negedge clk);
            wr_en = 1'b0;
            rd(4'd8, v);
            chk("R2 before match", v, 0);
            repeat (6) @(negedge clk);
            rd(4'd8, v);
            chk("R2/R10 compare bit", v, 16'h0080 >> i);
        end

        // R3: equal value written on a held count does not flag
        wr(4'd8, 16'h00FF);
        @(negedge clk);
        hold = 1'b1;
        wr(4'd0, cnt);
        repeat (4) @(negedge clk);
        rd(4'd8, v);
        chk("R3 held equal", v, 0);
        hold = 1'b0;
        @(negedge clk);
        wr(4'd0, cnt + 16'd3);
        repeat (5) @(negedge clk);
        rd(4'd8, v);
        chk("R3 later match", v, 16'h0080);

        // R4-R7/R10: sweep channel, edge code and pin direction
        for (int j = 0; j < 3; j++) begin
            for (int m = 0; m < 4; m++) begin
                wr(4'd10, 16'(m << (4 - 2 * j)));
                wr(4'd8, 16'h00FF);
                for (int dir = 1; dir >= 0; dir--) begin
                    rd(4'(5 + j), prev);
                    @(negedge clk);
                    pin[j] = dir[0];
                    c = cnt;
                    repeat (6) @(negedge clk);
                    rd(4'd8, v);
                    if ((dir == 1 && (m == 1 || m == 3)) || (dir == 0 && (m == 2 || m == 3))) begin
                        chk("R4/R5/R6 flag", v, 16'h0004 >> j);
                        rd(4'(5 + j), v);
                        chk("R4/R5/R6 latch", v, c + 16'd2);
                    end else begin
                        chk("R5/R7 no flag", v, 0);
                        rd(4'(5 + j), v);
                        chk("R7 latch kept", v, prev);
                    end
                    wr(4'd8, 16'h00FF);
                end
            end
        end

        // R11: capture latch is read-only
        rd(4'd5, prev);
        wr(4'd5, 16'h1234);
        rd(4'd5, v);
        chk("R11", v, prev);

        // Build flag pattern: OC2, OC4 and all capture channels
        wr(4'd10, 16'h003F);
        @(negedge clk);
        pin = 3'b111;
        repeat (5) @(negedge clk);
        wr(4'd1, cnt + 16'd4);
        wr(4'd3, cnt + 16'd4);
        repeat (6) @(negedge clk);
        rd(4'd8, v);
        chk("R10 pattern", v, 16'h0057);

        // R9: sweep every mask value against the fixed pattern
        for (int mk = 0; mk < 256; mk++) begin
            wr(4'd9, 16'(mk));
            #1 chk("R9 irq", irq, |(8'h57 & 8'(mk)));
        end

        // R8: zero data leaves flags; one clears exactly its bit
        wr(4'd8, 16'h0000);
        rd(4'd8, v);
        chk("R8 zero write", v, 16'h0057);
        wr(4'd8, 16'h0010);
        rd(4'd8, v);
        chk("R8 one bit", v, 16'h0047);
        wr(4'd8, 16'h0005);
        rd(4'd8, v);
        chk("R8 two bits", v, 16'h0042);

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end
endmodule